// File: doc/BRIEF.md
# Context Switch Request Sequencer

This block carries out processor context switches on behalf of a small interrupt coprocessor. The coprocessor presents a switch request together with the memory address of the context it wants to run. The sequencer first holds instruction fetch, then waits for every execution unit to go quiet. It writes the live register image to memory at the address held in its context pointer, moves the requested address into that pointer, reads the new image back word by word and lets execution continue.

The pointer always names the context that is currently running, so a save lands where that context was last loaded from. A request for the context that is already running is not dropped. The save is skipped and the image is read back again, which restarts that context's code. Requests that arrive while a switch is running wait in a single-entry queue. The requester is held off while that entry is occupied.

The image is a fixed number of 32-bit words laid out contiguously in memory. Memory is reached through a single word port with a valid/ready request handshake and a separate read-data strobe. The port may hold off for any number of cycles.

Top module: `ctxsw_sequencer`

## Requirements
- R1: After reset, `ctx_ptr_o` equals the parameter `PTR_RESET`, and `fetch_suspend_o`, `busy_o`, `done_o`, `req_stall_o` and `mem_valid_o` are all low.
- R2: Once a request is taken, `fetch_suspend_o` is high before any memory request is issued. No memory request is issued while `exec_idle_i` is low after the request is taken.
- R3: For a switch to a different address, N_WORDS writes are made. Write k goes to the old pointer plus 4·k and carries `save_image_i[32k+31:32k]`. The pointer keeps its old value while these writes are made.
- R4: After the save, `ctx_ptr_o` takes the requested address. N_WORDS reads are then made from the new address plus 4·k. Read word k appears on `restore_image_o[32k+31:32k]`.
- R5: A request whose address equals `ctx_ptr_o` issues no memory writes. It still reloads all N_WORDS words from that address and ends with a done pulse.
- R6: A request is taken on a clock edge where `req_valid_i` is high and `req_stall_o` is low. `req_stall_o` is high while one request is queued and not yet started. A request taken during a switch runs after the current switch completes. Requests offered while stalled are not taken.
- R7: `fetch_suspend_o` stays high without a gap from the cycle after the request is started until the final read word is received. Memory requests are issued only while it is high.
- R8: A memory request holds `mem_valid_o`, `mem_addr_o` and `mem_write_o` steady until `mem_ready_i` is seen. After a read request is accepted, no new request is issued until `mem_rvalid_i` returns the word.
- R9: `done_o` is high for exactly one cycle per completed switch. That cycle is the first cycle after the load in which `fetch_suspend_o` is low.
- R10: `busy_o` is high from the cycle after a request is started through the done cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Switch request from the coprocessor |
| req_addr_i | input | AW | Address of the requested context |
| req_stall_o | output | 1 | Queue occupied; requester must hold |
| exec_idle_i | input | 1 | All execution units are idle |
| fetch_suspend_o | output | 1 | Hold instruction fetch |
| busy_o | output | 1 | Switch in progress |
| done_o | output | 1 | One-cycle pulse when execution resumes |
| ctx_ptr_o | output | AW | Address of the running context |
| save_image_i | input | 32·N_WORDS | Live register image to be saved |
| restore_image_o | output | 32·N_WORDS | Image read from the new context |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_write_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rvalid_i | input | 1 | Read data strobe |
| mem_rdata_i | input | 32 | Read data |

## Verification
The switch path is swept over every combination of four memory-ready duty patterns, three read-return latencies and three idle-wait delays, with targets rotating across six context slots. The ready and latency patterns show whether the handshake holds requests and waits for read data, rather than relying on a fast memory. The idle delay shows whether memory is touched before the execution units drain. Requests for the running context are mixed in; they show the skipped save by a write count of zero while the image still comes back. A queued second request and a third offered under stall separate correct one-deep queueing from loss or over-acceptance.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned WORD_BYTES = 4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DRAIN,
        SQ_SAVE,
        SQ_LOAD,
        SQ_RESUME
    } seq_state_e;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_ISSUE,
        WK_WAIT_RD
    } walk_state_e;

endpackage

// File: rtl/ctxsw_req_slot.sv
module ctxsw_req_slot #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid_i,
    input  logic [AW-1:0] push_addr_i,
    input  logic          pop_i,
    output logic          stall_o,
    output logic          full_o,
    output logic [AW-1:0] addr_o
);

    typedef struct packed {
        logic          full;
        logic [AW-1:0] addr;
    } slot_t;

    slot_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (pop_i) begin
            s_d.full = 1'b0;
        end
        if (push_valid_i && !s_q.full) begin
            s_d.full = 1'b1;
            s_d.addr = push_addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign stall_o = s_q.full;
    assign full_o  = s_q.full;
    assign addr_o  = s_q.addr;

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.full && !pop_i |=> s_q.full && $stable(s_q.addr)); // R6

    AST_POP_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> s_q.full); // R6

endmodule

// File: rtl/ctxsw_word_walker.sv
module ctxsw_word_walker
    import ctxsw_pkg::*;
#(
    parameter int unsigned AW      = 32,
    parameter int unsigned N_WORDS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      write_i,
    input  logic [AW-1:0]             base_i,
    input  logic [N_WORDS*WORD_W-1:0] image_i,
    output logic                      done_o,
    output logic                      wr_en_o,
    output logic [IDX_W-1:0]          wr_idx_o,
    output logic [WORD_W-1:0]         wr_data_o,
    output logic                      mem_valid_o,
    input  logic                      mem_ready_i,
    output logic                      mem_write_o,
    output logic [AW-1:0]             mem_addr_o,
    output logic [WORD_W-1:0]         mem_wdata_o,
    input  logic                      mem_rvalid_i,
    input  logic [WORD_W-1:0]         mem_rdata_i
);

    localparam int unsigned IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

    typedef struct packed {
        walk_state_e      st;
        logic             write;
        logic [AW-1:0]    base;
        logic [IDX_W-1:0] idx;
        logic             done;
    } walk_t;

    walk_t r_q, r_d;
    logic  last_word;

    assign last_word = (r_q.idx == LAST_IDX);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        wr_en_o  = 1'b0;
        unique case (r_q.st)
            WK_IDLE: begin
                if (start_i) begin
                    r_d.st    = WK_ISSUE;
                    r_d.write = write_i;
                    r_d.base  = base_i;
                    r_d.idx   = '0;
                end
            end
            WK_ISSUE: begin
                if (mem_ready_i) begin
                    if (r_q.write) begin
                        if (last_word) begin
                            r_d.st   = WK_IDLE;
                            r_d.done = 1'b1;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end else begin
                        r_d.st = WK_WAIT_RD;
                    end
                end
            end
            WK_WAIT_RD: begin
                if (mem_rvalid_i) begin
                    wr_en_o = 1'b1;
                    if (last_word) begin
                        r_d.st   = WK_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = WK_ISSUE;
                    end
                end
            end
            default: r_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: WK_IDLE, write: 1'b0, base: '0, idx: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o      = r_q.done;
    assign wr_idx_o    = r_q.idx;
    assign wr_data_o   = mem_rdata_i;
    assign mem_valid_o = (r_q.st == WK_ISSUE);
    assign mem_write_o = r_q.write;
    assign mem_addr_o  = r_q.base + AW'({r_q.idx, 2'b00});
    assign mem_wdata_o = image_i[r_q.idx*WORD_W +: WORD_W];

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_write_o)); // R8

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (r_q.st == WK_IDLE)); // R7

    AST_RDATA_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !mem_valid_o); // R8

endmodule

// File: rtl/ctxsw_image_reg.sv
module ctxsw_image_reg
    import ctxsw_pkg::*;
#(
    parameter int unsigned N_WORDS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [IDX_W-1:0]          wr_idx_i,
    input  logic [WORD_W-1:0]         wr_data_i,
    output logic [N_WORDS*WORD_W-1:0] image_o
);

    localparam int unsigned IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    logic [WORD_W-1:0] img_q [N_WORDS];
    logic [WORD_W-1:0] img_d [N_WORDS];

    always_comb begin
        img_d = img_q;
        if (wr_en_i) begin
            img_d[wr_idx_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < int'(N_WORDS); w++) begin
                img_q[w] <= '0;
            end
        end else begin
            img_q <= img_d;
        end
    end

    for (genvar g = 0; g < int'(N_WORDS); g++) begin : g_word
        assign image_o[g*WORD_W +: WORD_W] = img_q[g];
    end

endmodule

// File: rtl/ctxsw_sequencer.sv
module ctxsw_sequencer
    import ctxsw_pkg::*;
#(
    parameter int unsigned   AW        = 32,
    parameter int unsigned   N_WORDS   = 4,
    parameter logic [AW-1:0] PTR_RESET = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid_i,
    input  logic [AW-1:0]             req_addr_i,
    output logic                      req_stall_o,
    input  logic                      exec_idle_i,
    output logic                      fetch_suspend_o,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [AW-1:0]             ctx_ptr_o,
    input  logic [N_WORDS*WORD_W-1:0] save_image_i,
    output logic [N_WORDS*WORD_W-1:0] restore_image_o,
    output logic                      mem_valid_o,
    input  logic                      mem_ready_i,
    output logic                      mem_write_o,
    output logic [AW-1:0]             mem_addr_o,
    output logic [WORD_W-1:0]         mem_wdata_o,
    input  logic                      mem_rvalid_i,
    input  logic [WORD_W-1:0]         mem_rdata_i
);

    localparam int unsigned IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] target;
        logic          reload;
        logic [AW-1:0] ptr;
    } seq_t;

    seq_t q, n;

    logic              slot_full;
    logic [AW-1:0]     slot_addr;
    logic              pop;
    logic              walk_start;
    logic              walk_write;
    logic [AW-1:0]     walk_base;
    logic              walk_done;
    logic              img_we;
    logic [IDX_W-1:0]  img_idx;
    logic [WORD_W-1:0] img_data;

    ctxsw_req_slot #(.AW(AW)) u_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_valid_i (req_valid_i),
        .push_addr_i  (req_addr_i),
        .pop_i        (pop),
        .stall_o      (req_stall_o),
        .full_o       (slot_full),
        .addr_o       (slot_addr)
    );

    ctxsw_word_walker #(.AW(AW), .N_WORDS(N_WORDS)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (walk_start),
        .write_i      (walk_write),
        .base_i       (walk_base),
        .image_i      (save_image_i),
        .done_o       (walk_done),
        .wr_en_o      (img_we),
        .wr_idx_o     (img_idx),
        .wr_data_o    (img_data),
        .mem_valid_o  (mem_valid_o),
        .mem_ready_i  (mem_ready_i),
        .mem_write_o  (mem_write_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i)
    );

    ctxsw_image_reg #(.N_WORDS(N_WORDS)) u_img (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (img_we),
        .wr_idx_i  (img_idx),
        .wr_data_i (img_data),
        .image_o   (restore_image_o)
    );

    always_comb begin
        n          = q;
        pop        = 1'b0;
        walk_start = 1'b0;
        walk_write = 1'b0;
        walk_base  = q.ptr;
        unique case (q.st)
            SQ_IDLE: begin
                if (slot_full) begin
                    pop      = 1'b1;
                    n.target = slot_addr;
                    n.reload = (slot_addr == q.ptr);
                    n.st     = SQ_DRAIN;
                end
            end
            SQ_DRAIN: begin
                if (exec_idle_i) begin
                    walk_start = 1'b1;
                    if (q.reload) begin
                        walk_write = 1'b0;
                        walk_base  = q.target;
                        n.st       = SQ_LOAD;
                    end else begin
                        walk_write = 1'b1;
                        walk_base  = q.ptr;
                        n.st       = SQ_SAVE;
                    end
                end
            end
            SQ_SAVE: begin
                if (walk_done) begin
                    n.ptr      = q.target;
                    walk_start = 1'b1;
                    walk_write = 1'b0;
                    walk_base  = q.target;
                    n.st       = SQ_LOAD;
                end
            end
            SQ_LOAD: begin
                if (walk_done) begin
                    n.st = SQ_RESUME;
                end
            end
            SQ_RESUME: begin
                n.st = SQ_IDLE;
            end
            default: n.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, target: '0, reload: 1'b0, ptr: PTR_RESET};
        end else begin
            q <= n;
        end
    end

    assign fetch_suspend_o = (q.st == SQ_DRAIN) || (q.st == SQ_SAVE) || (q.st == SQ_LOAD);
    assign busy_o          = (q.st != SQ_IDLE);
    assign done_o          = (q.st == SQ_RESUME);
    assign ctx_ptr_o       = q.ptr;

    AST_NO_ACCESS_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_DRAIN) |-> !mem_valid_o); // R2

    AST_ACCESS_SUSPENDED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |-> fetch_suspend_o); // R7

    AST_RELOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        q.reload && mem_valid_o |-> !mem_write_o); // R5

    AST_PTR_HELD_IN_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == SQ_SAVE) && !walk_done |=> $stable(ctx_ptr_o)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_SUSPEND_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fetch_suspend_o) |-> done_o); // R7

endmodule

// File: tb/ctxsw_sequencer_tb.sv
`timescale 1ns/1ps
module ctxsw_sequencer_tb;

    localparam int          AW   = 32;
    localparam int          N    = 4;
    localparam logic [31:0] PRST = 32'h0000_00F0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid_i = 1'b0;
    logic [AW-1:0]   req_addr_i = '0;
    logic            req_stall_o;
    logic            exec_idle_i = 1'b0;
    logic            fetch_suspend_o;
    logic            busy_o;
    logic            done_o;
    logic [AW-1:0]   ctx_ptr_o;
    logic [N*32-1:0] save_image_i = '0;
    logic [N*32-1:0] restore_image_o;
    logic            mem_valid_o;
    logic            mem_ready_i = 1'b0;
    logic            mem_write_o;
    logic [AW-1:0]   mem_addr_o;
    logic [31:0]     mem_wdata_o;
    logic            mem_rvalid_i = 1'b0;
    logic [31:0]     mem_rdata_i = '0;

    always #2 clk = ~clk;

    ctxsw_sequencer #(.AW(AW), .N_WORDS(N), .PTR_RESET(PRST)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_stall_o(req_stall_o),
        .exec_idle_i(exec_idle_i), .fetch_suspend_o(fetch_suspend_o),
        .busy_o(busy_o), .done_o(done_o), .ctx_ptr_o(ctx_ptr_o),
        .save_image_i(save_image_i), .restore_image_o(restore_image_o),
        .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i), .mem_write_o(mem_write_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    logic [31:0] mem [64];
    int          ready_mode = 0;
    int          rd_lat = 0;
    int          cyc = 0;
    logic        rd_pend = 1'b0;
    int          rd_cnt = 0;
    logic [31:0] rd_data = '0;
    int          wr_cnt = 0;
    int          done_cnt = 0;
    logic        done_prev = 1'b0;
    int          bad_access = 0;
    int          bad_done = 0;
    int          done_long = 0;
    int          bad_atomic = 0;
    logic [31:0] exp_ptr = PRST;
    int          sw_no = 0;

    // memory model and port monitors
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_ready_i <= (ready_mode == 0) ? 1'b1 : ((cyc % (ready_mode + 1)) == ready_mode);
        mem_rvalid_i <= 1'b0;
        if (rd_pend) begin
            if (rd_cnt == 0) begin
                mem_rvalid_i <= 1'b1;
                mem_rdata_i  <= rd_data;
                rd_pend      <= 1'b0;
            end else begin
                rd_cnt <= rd_cnt - 1;
            end
        end
        if (rst_n && mem_valid_o && mem_ready_i) begin
            if (mem_write_o) begin
                mem[mem_addr_o[7:2]] = mem_wdata_o;
                wr_cnt = wr_cnt + 1;
            end else begin
                rd_pend <= 1'b1;
                rd_cnt  <= rd_lat;
                rd_data <= mem[mem_addr_o[7:2]];
            end
            if (!fetch_suspend_o || !exec_idle_i) bad_access = bad_access + 1;
        end
        if (rst_n) begin
            if (done_o) done_cnt = done_cnt + 1;
            if (done_o && done_prev) done_long = done_long + 1;
            if (done_o && fetch_suspend_o) bad_done = bad_done + 1;
            if (busy_o && !done_o && !fetch_suspend_o) bad_atomic = bad_atomic + 1;
            done_prev <= done_o;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] img_word(input int s, input int k);
        return 32'hC000_0000 | (32'(s) << 8) | 32'(k);
    endfunction

    task automatic set_image();
        sw_no++;
        for (int k = 0; k < N; k++) save_image_i[k*32 +: 32] = img_word(sw_no, k);
    endtask

    task automatic send_req(input logic [31:0] a);
        @(negedge clk);
        while (req_stall_o) @(negedge clk);
        req_valid_i = 1'b1;
        req_addr_i  = a;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    task automatic wait_suspend();
        int guard = 0;
        while (!fetch_suspend_o && guard < 50) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic wait_done(input int target);
        int guard = 0;
        while (done_cnt < target && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    task automatic do_switch(input logic [31:0] a, input int dly);
        logic [31:0] snap [N];
        logic [31:0] old;
        bit          reload;
        int          w0, d0;
        old    = exp_ptr;
        reload = (a == old);
        for (int k = 0; k < N; k++) snap[k] = mem[a[7:2] + k];
        w0 = wr_cnt;
        d0 = done_cnt;
        set_image();
        exec_idle_i = 1'b0;
        send_req(a);
        wait_suspend();
        chk(fetch_suspend_o, "R2", "suspend before idle", 32'(fetch_suspend_o), 1);
        chk(busy_o, "R10", "busy during drain", 32'(busy_o), 1);
        repeat (dly) @(negedge clk);
        exec_idle_i = 1'b1;
        wait_done(d0 + 1);
        chk(ctx_ptr_o == a, "R4", "pointer updated", ctx_ptr_o, a);
        for (int k = 0; k < N; k++)
            chk(restore_image_o[k*32 +: 32] == snap[k], reload ? "R5" : "R4", "restored word",
                restore_image_o[k*32 +: 32], snap[k]);
        if (reload) begin
            chk(wr_cnt == w0, "R5", "no writes on reload", 32'(wr_cnt - w0), 0);
        end else begin
            chk(wr_cnt - w0 == N, "R3", "write count", 32'(wr_cnt - w0), N);
            for (int k = 0; k < N; k++)
                chk(mem[old[7:2] + k] == img_word(sw_no, k), "R3", "saved word",
                    mem[old[7:2] + k], img_word(sw_no, k));
        end
        chk(done_cnt - d0 == 1, "R9", "one done pulse", 32'(done_cnt - d0), 1);
        chk(!busy_o && !fetch_suspend_o, "R10", "idle after switch", 32'(busy_o), 0);
        exp_ptr = a;
    endtask

    task automatic queue_test();
        logic [31:0] old, a, b, c;
        logic [31:0] snap_b [N];
        int          w0, d0;
        old = exp_ptr;
        a = (old == 32'h10) ? 32'h20 : 32'h10;
        b = 32'h40;
        c = 32'h50;
        for (int k = 0; k < N; k++) snap_b[k] = mem[b[7:2] + k];
        w0 = wr_cnt;
        d0 = done_cnt;
        set_image();
        exec_idle_i = 1'b0;
        send_req(a);
        wait_suspend();
        chk(!req_stall_o, "R6", "queue free after start", 32'(req_stall_o), 0);
        req_valid_i = 1'b1;
        req_addr_i  = b;
        @(negedge clk);
        req_addr_i  = c;
        chk(req_stall_o, "R6", "stall with queued request", 32'(req_stall_o), 1);
        repeat (3) @(negedge clk);
        chk(req_stall_o, "R6", "stall held while switch waits", 32'(req_stall_o), 1);
        req_valid_i = 1'b0;
        exec_idle_i = 1'b1;
        wait_done(d0 + 2);
        repeat (20) @(negedge clk);
        chk(done_cnt - d0 == 2, "R6", "exactly two switches ran", 32'(done_cnt - d0), 2);
        chk(ctx_ptr_o == b, "R6", "queued target is final", ctx_ptr_o, b);
        chk(wr_cnt - w0 == 2 * N, "R3", "two saves", 32'(wr_cnt - w0), 2 * N);
        for (int k = 0; k < N; k++) begin
            chk(restore_image_o[k*32 +: 32] == snap_b[k], "R4", "queued restore",
                restore_image_o[k*32 +: 32], snap_b[k]);
            chk(mem[a[7:2] + k] == img_word(sw_no, k), "R3", "second save at first target",
                mem[a[7:2] + k], img_word(sw_no, k));
        end
        chk(!req_stall_o, "R6", "stall released", 32'(req_stall_o), 0);
        exp_ptr = b;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h5A00_0000 | 32'(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ctx_ptr_o == PRST, "R1", "reset pointer", ctx_ptr_o, PRST);
        chk(!fetch_suspend_o && !busy_o && !done_o, "R1", "reset flags",
            {29'd0, fetch_suspend_o, busy_o, done_o}, 0);
        chk(!req_stall_o && !mem_valid_o, "R1", "reset stall/mem",
            {30'd0, req_stall_o, mem_valid_o}, 0);
        begin
            int s = 0;
            for (int rm = 0; rm < 4; rm++) begin
                for (int lat = 0; lat < 3; lat++) begin
                    for (int d = 0; d < 3; d++) begin
                        logic [31:0] tgt;
                        ready_mode = rm;
                        rd_lat     = lat;
                        if (s % 4 == 3) tgt = exp_ptr;
                        else tgt = 32'(((s * 5 + 1) % 6) * 16);
                        do_switch(tgt, d);
                        s++;
                    end
                end
            end
        end
        ready_mode = 2;
        rd_lat     = 1;
        queue_test();
        chk(bad_access == 0, "R7", "accesses only while suspended and idle", 32'(bad_access), 0);
        chk(bad_atomic == 0, "R7", "suspend gap during switch", 32'(bad_atomic), 0);
        chk(done_long == 0, "R9", "done wider than one cycle", 32'(done_long), 0);
        chk(bad_done == 0, "R9", "done while suspended", 32'(bad_done), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule